// File: doc/BRIEF.md
# I2C Master SCL Period Generator

This block produces the serial clock of an I2C master from the system clock, along with the SDA transitions that frame a transfer (the START and STOP conditions). Two sets of timing counts are held, one for standard-mode operation and one for fast-mode operation. Each set has a count for the high part of the SCL period and a count for the low part. A speed bit in the control register picks which set is in use. Each phase length is the programmed count plus a fixed internal overhead. The low phase is timed from the cycle in which the block drives SCL low. The START hold time is derived from the high count.

Software programs the counts and the speed bit while the generator is disabled, then enables it. A one-cycle `start_req` opens a transfer. From then on SCL toggles continuously. A one-cycle `stop_req` closes the transfer at the end of the next low phase. `busy` is high from the START condition until the STOP condition has completed. Byte shifting, addressing, pad drivers, clock stretching and high-speed mode are handled elsewhere. SDA is held low for the whole transfer here.

Top module: `scl_period_gen`

## Requirements
- R1: While the enable bit (register address 1, data bit 0) is 0, `scl_o` and `sda_o` are 1 and `busy` is 0. This holds from reset, and reset leaves the generator disabled.
- R2: A `start_req` pulse while enabled and idle sets `busy` at the next clock edge. It drives `sda_o` low with `scl_o` high for H+3 cycles before SCL first falls. H is the effective high count.
- R3: Every SCL low phase lasts L+1 cycles, where L is the effective low count.
- R4: Every SCL high phase inside a transfer lasts H+8 cycles.
- R5: Control register address 0, data bit 0 selects the count set. 0 selects standard mode: high count at address 2, low count at address 4. 1 selects fast mode: high count at address 3, low count at address 5.
- R6: The effective count is the programmed 16-bit count, except that values below 6 are raised to 6.
- R7: Writes to addresses 0, 2, 3, 4 and 5 are ignored while the generator is enabled. The previously written values stay in use.
- R8: After a `stop_req` pulse during a transfer, the current low phase completes. SCL then rises with SDA still low for H+3 cycles. After that SDA rises with SCL high and `busy` falls. SDA never changes while SCL is low.
- R9: Writing 0 to the enable bit during a transfer releases `scl_o` and `sda_o` and clears `busy` from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| start_req | input | 1 | Pulse: begin a transfer with a START condition |
| stop_req | input | 1 | Pulse: end the transfer with a STOP condition |
| scl_o | output | 1 | Serial clock level (1 = released) |
| sda_o | output | 1 | Serial data level for START/STOP framing (1 = released) |
| busy | output | 1 | Bus activity: START through STOP completion |

## Verification
The checker enforces four rules on every cycle:
- The disabled state releases both lines and clears `busy`.
- SDA falls only while SCL is high.
- SDA rises only while SCL is high, as long as the generator stays enabled.
- `busy` always coincides with SDA held low, and no low phase is shorter than the clamped minimum.

Only the bench scenarios can show the exact phase lengths for a given count set. The same holds for choosing between the two sets, the clamping of small counts, and writes being ignored while enabled. The bench checks these by comparing every measured SCL/SDA segment against a predicted list.

// File: rtl/sclg_pkg.sv
package sclg_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_ENABLE = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNT0   = 3'd2;
  localparam int NUM_CNT = 4;

  localparam int OVH_HIGH = 8;
  localparam int OVH_LOW  = 1;
  localparam int OVH_HOLD = 3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_HOLD, PH_LOW, PH_HIGH, PH_STOP
  } phase_e;
endpackage

// File: rtl/sclg_regs.sv
module sclg_regs
  import sclg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              enable,
  output logic [CNT_W-1:0]  hi_eff,
  output logic [CNT_W-1:0]  lo_eff
);
  logic             speed_q;
  logic             en_q;
  logic [CNT_W-1:0] cnt_q [NUM_CNT];
  logic             cfg_we;

  // configuration accepted only while disabled
  assign cfg_we = wr_en && !en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      speed_q <= 1'b0;
    end else begin
      if (wr_en && wr_addr == A_ENABLE) en_q <= wr_data[0];
      if (cfg_we && wr_addr == A_CTRL) speed_q <= wr_data[0];
    end
  end

  // index: 0 std high, 1 fast high, 2 std low, 3 fast low
  for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[gi] <= CNT_W'(MIN_CNT);
      else if (cfg_we && wr_addr == ADDR_W'(A_CNT0 + gi)) cnt_q[gi] <= wr_data;
    end
  end

  logic [CNT_W-1:0] hi_raw, lo_raw;
  always_comb begin
    hi_raw = speed_q ? cnt_q[1] : cnt_q[0];
    lo_raw = speed_q ? cnt_q[3] : cnt_q[2];
    hi_eff = (hi_raw < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : hi_raw;
    lo_eff = (lo_raw < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : lo_raw;
  end

  assign enable = en_q;
endmodule

// File: rtl/sclg_timer.sv
module sclg_timer #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)               cnt_d = '0;
    else if (load)         cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sclg_seq.sv
module sclg_seq
  import sclg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int W     = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic [CNT_W-1:0] hi_eff,
  input  logic [CNT_W-1:0] lo_eff,
  input  logic             done,
  output logic             clr,
  output logic             load,
  output logic [W-1:0]     load_val,
  output logic             scl_o,
  output logic             sda_o,
  output logic             busy
);
  phase_e ph_q, ph_d;
  logic   stop_q, stop_d;
  logic [W-1:0] len_hold, len_low, len_high;

  // timer reloads with phase length minus one
  assign len_hold = W'(hi_eff) + W'(OVH_HOLD - 1);
  assign len_low  = W'(lo_eff) + W'(OVH_LOW - 1);
  assign len_high = W'(hi_eff) + W'(OVH_HIGH - 1);

  always_comb begin
    ph_d     = ph_q;
    stop_d   = stop_q || (stop_req && ph_q != PH_IDLE);
    load     = 1'b0;
    load_val = '0;
    clr      = !enable;
    if (!enable) begin
      ph_d   = PH_IDLE;
      stop_d = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_req) begin
          ph_d = PH_HOLD; load = 1'b1; load_val = len_hold;
        end
        PH_HOLD: if (done) begin
          ph_d = PH_LOW; load = 1'b1; load_val = len_low;
        end
        PH_LOW: if (done) begin
          load = 1'b1;
          if (stop_d) begin
            ph_d = PH_STOP; load_val = len_hold; stop_d = 1'b0;
          end else begin
            ph_d = PH_HIGH; load_val = len_high;
          end
        end
        PH_HIGH: if (done) begin
          ph_d = PH_LOW; load = 1'b1; load_val = len_low;
        end
        PH_STOP: if (done) ph_d = PH_IDLE;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      stop_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      stop_q <= stop_d;
    end
  end

  // disable releases the lines in the same cycle enable drops
  assign busy  = enable && (ph_q != PH_IDLE);
  assign scl_o = !enable || (ph_q != PH_LOW);
  assign sda_o = !busy;
endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import sclg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MIN_CNT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              start_req,
  input  logic              stop_req,
  output logic              scl_o,
  output logic              sda_o,
  output logic              busy
);
  localparam int TW = CNT_W + 1;

  logic             enable;
  logic [CNT_W-1:0] hi_eff, lo_eff;
  logic             t_clr, t_load, t_done;
  logic [TW-1:0]    t_val;

  sclg_regs #(.CNT_W(CNT_W), .MIN_CNT(MIN_CNT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .enable(enable), .hi_eff(hi_eff), .lo_eff(lo_eff)
  );

  sclg_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .load(t_load),
    .load_val(t_val), .done(t_done)
  );

  sclg_seq #(.CNT_W(CNT_W), .W(TW)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_req(start_req),
    .stop_req(stop_req), .hi_eff(hi_eff), .lo_eff(lo_eff), .done(t_done),
    .clr(t_clr), .load(t_load), .load_val(t_val),
    .scl_o(scl_o), .sda_o(sda_o), .busy(busy)
  );
endmodule

// File: rtl/sclg_checker.sv
module sclg_checker #(
  parameter int MIN_LOW = 7
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic scl_o,
  input logic sda_o,
  input logic busy
);
  int unsigned low_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_run <= 0;
    else if (scl_o)  low_run <= 0;
    else             low_run <= low_run + 1;
  end

  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (scl_o && sda_o && !busy));

  a_r2_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_o) |-> (scl_o && $past(scl_o)));

  a_r8_stop_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_o) && enable) |-> (scl_o && $past(scl_o)));

  a_r8_busy_sda_low: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_o);

  a_r3_low_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_o) && enable) |-> (low_run >= MIN_LOW));
endmodule

bind scl_period_gen sclg_checker #(.MIN_LOW(MIN_CNT + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .scl_o(scl_o), .sda_o(sda_o), .busy(busy)
);

// File: tb/scl_period_gen_bench.sv
module scl_period_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        start_req = 1'b0;
  logic        stop_req = 1'b0;
  logic        scl_o, sda_o, busy;

  int total = 0;
  int bad = 0;
  int expq[$];
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  scl_period_gen u_scl_period_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start_req(start_req), .stop_req(stop_req),
    .scl_o(scl_o), .sda_o(sda_o), .busy(busy)
  );

  function automatic int eff(int v);
    return (v < 6) ? 6 : v;
  endfunction

  function automatic int code(bit s, bit d, int len);
    return (s * 2 + d) * 100000 + len;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: measures busy segments of constant {scl,sda}
  int prev_c = -1;
  int run = 0;
  bit prev_busy = 1'b0;
  always @(negedge clk) begin
    int cur;
    cur = code(scl_o, sda_o, 0);
    if (cur == prev_c && busy == prev_busy) run++;
    else begin
      if (mon_on && prev_busy) begin
        if (expq.size() == 0) check(1'b0, "R2/R3/R4/R8 unexpected segment", prev_c + run, -1);
        else begin
          int e;
          e = expq.pop_front();
          check(e == prev_c + run, "R2/R3/R4/R8 segment", prev_c + run, e);
        end
      end
      prev_c = cur; prev_busy = busy; run = 1;
    end
  end

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: predict segments, then run a transfer of k low phases
  task automatic xfer(int hi, int lo, int k, string req);
    int falls;
    bit last;
    expq.push_back(code(1, 0, eff(hi) + 3));
    for (int i = 1; i < k; i++) begin
      expq.push_back(code(0, 0, eff(lo) + 1));
      expq.push_back(code(1, 0, eff(hi) + 8));
    end
    expq.push_back(code(0, 0, eff(lo) + 1));
    expq.push_back(code(1, 0, eff(hi) + 3));
    mon_on = 1'b1;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    check(busy && !sda_o && scl_o, {req, " R2 busy after start"}, {busy, sda_o, scl_o}, 3'b101);
    falls = 0; last = scl_o;
    while (falls < k) begin
      @(negedge clk);
      if (last && !scl_o) falls++;
      last = scl_o;
    end
    stop_req = 1'b1;
    @(negedge clk); stop_req = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, {req, " R8 all segments seen"}, expq.size(), 0);
    check(scl_o && sda_o && !busy, {req, " R8 idle after stop"}, {scl_o, sda_o, busy}, 3'b110);
    expq.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl_o && sda_o && !busy, "R1 reset state", {scl_o, sda_o, busy}, 3'b110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(scl_o && sda_o && !busy, "R1 disabled after reset", {scl_o, sda_o, busy}, 3'b110);

    // standard-mode set
    wr(3'd2, 10); wr(3'd4, 12); wr(3'd3, 7); wr(3'd5, 9); wr(3'd0, 0);
    wr(3'd1, 1);
    xfer(10, 12, 3, "R3 R4 R5 std");

    // fast-mode set
    wr(3'd1, 0); wr(3'd0, 1); wr(3'd1, 1);
    xfer(7, 9, 2, "R5 fast");

    // clamp of small counts
    wr(3'd1, 0); wr(3'd0, 0); wr(3'd2, 2); wr(3'd4, 0); wr(3'd1, 1);
    xfer(2, 0, 2, "R6 clamp");

    // writes while enabled are ignored
    wr(3'd2, 40); wr(3'd4, 30); wr(3'd0, 1);
    xfer(2, 0, 1, "R7 locked");

    // disable mid-transfer
    mon_on = 1'b0;
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    repeat (15) @(negedge clk);
    check(busy, "R9 busy before disable", busy, 1);
    @(negedge clk); wr_en = 1'b1; wr_addr = 3'd1; wr_data = 16'd0;
    @(negedge clk); wr_en = 1'b0;
    check(scl_o && sda_o && !busy, "R9 released after disable", {scl_o, sda_o, busy}, 3'b110);
    repeat (5) @(negedge clk);
    check(scl_o && sda_o && !busy, "R1 stays idle while disabled", {scl_o, sda_o, busy}, 3'b110);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule